// File: doc/BRIEF.md
# Phase-Seeded Fractional Divide Modulator

This block produces the per-cycle feedback divide value for a fractional-N synthesizer. It runs on the phase-detector comparison clock, one step per comparison cycle. Each cycle it outputs an integer part plus a one-bit modulated offset, so that the long-run average divide ratio is INT + FRAC/MOD. A first-order modulo-MOD accumulator generates the offset: whenever adding FRAC to the running residue reaches MOD or more, that cycle divides by INT + 1, and the residue wraps.

Any accepted update of INT, FRAC and MOD also reloads the accumulator with a programmable PHASE word. The new settings and the seed take effect on the same cycle. The carry pattern, and with it the quantization error sequence, therefore depends only on FRAC, MOD and PHASE. The same update repeated gives the same sequence. PHASE offsets the synthesized output phase in steps of one MOD-th of a full turn. An update whose values are out of range is dropped whole, and the running sequence carries on.

Top module: `fracSdm`

## Requirements
- R1: After reset, nOut is 0 and residue is 0 (stored INT 0, FRAC 0, MOD 1), until the first accepted update.
- R2: An update is accepted when updStb is high at a clock edge with modIn != 0, fracIn < modIn and phaseIn < modIn. From that edge on, residue equals phaseIn and the new INT, FRAC and MOD are in force.
- R3: On every edge that does not accept an update, residue becomes (residue + FRAC) mod MOD, using the stored FRAC and MOD.
- R4: nOut equals INT + 1 in a cycle where residue + FRAC >= MOD. Otherwise nOut equals INT.
- R5: Over the MOD consecutive cycles that start at an accepted seed, nOut equals INT + 1 in exactly FRAC of them.
- R6: An update with modIn = 0, fracIn >= modIn or phaseIn >= modIn is ignored. The stored settings stay as they were, and the residue advances as in R3.
- R7: Two accepted updates with identical INT, FRAC, MOD and PHASE yield identical nOut and residue sequences after each one.
- R8: When updStb is held high with valid values on consecutive edges, every one of those edges reseeds the accumulator, so residue stays at phaseIn.
- R9: With FRAC = 0, nOut stays equal to INT on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison-rate clock |
| rstN | input | 1 | Active-low asynchronous reset |
| updStb | input | 1 | Update strobe; applies the inputs below if valid |
| intIn | input | INT_W | Integer part of the divide ratio |
| fracIn | input | MOD_W | Fractional numerator |
| modIn | input | MOD_W | Fractional modulus |
| phaseIn | input | MOD_W | Accumulator seed |
| nOut | output | INT_W+1 | Divide value for the current cycle |
| residue | output | MOD_W | Accumulator contents |

## Verification
The critical collision is a seed and a carry falling on the same edge. Both the load and the accumulate path want to write the residue, and the outgoing carry must not leak into the new settings. The bench provokes this by reloading while the old sequence is carrying, by reseeding on back-to-back edges, and by sending invalid strobes in the middle of a run. A behavioural model, in which a load replaces the accumulate step, judges the nOut and residue values against it on every cycle.

// File: rtl/sdmPkg.sv
package sdmPkg;
  typedef struct packed {
    logic loadCfg;
    logic stepAcc;
  } sdmStrobe_t;
endpackage

// File: rtl/sdmCtrl.sv
module sdmCtrl
  import sdmPkg::*;
#(
  parameter int MOD_W = 12
) (
  input  logic             updStb,
  input  logic [MOD_W-1:0] fracIn,
  input  logic [MOD_W-1:0] modIn,
  input  logic [MOD_W-1:0] phaseIn,
  output sdmStrobe_t       strb
);
  logic cfgOk;

  always_comb begin
    cfgOk = (modIn != '0) && (fracIn < modIn) && (phaseIn < modIn);
    strb.loadCfg = updStb && cfgOk;
    strb.stepAcc = !(updStb && cfgOk);
  end
endmodule

// File: rtl/sdmPath.sv
module sdmPath
  import sdmPkg::*;
#(
  parameter int INT_W = 12,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  sdmStrobe_t       strb,
  input  logic [INT_W-1:0] intIn,
  input  logic [MOD_W-1:0] fracIn,
  input  logic [MOD_W-1:0] modIn,
  input  logic [MOD_W-1:0] phaseIn,
  output logic [INT_W:0]   nOut,
  output logic [MOD_W-1:0] residue
);
  localparam int SUM_W = MOD_W + 1;

  logic [INT_W-1:0] intR;
  logic [MOD_W-1:0] fracR;
  logic [MOD_W-1:0] modR;
  logic [MOD_W-1:0] accR;
  logic [SUM_W-1:0] accSum;
  logic [SUM_W-1:0] accWrap;
  logic             carry;

  always_comb begin
    accSum  = {1'b0, accR} + {1'b0, fracR};
    carry   = accSum >= {1'b0, modR};
    accWrap = carry ? (accSum - {1'b0, modR}) : accSum;
    nOut    = {1'b0, intR} + {{INT_W{1'b0}}, carry};
    residue = accR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intR  <= '0;
      fracR <= '0;
      modR  <= MOD_W'(1);
      accR  <= '0;
    end else if (strb.loadCfg) begin
      intR  <= intIn;
      fracR <= fracIn;
      modR  <= modIn;
      accR  <= phaseIn;
    end else if (strb.stepAcc) begin
      accR  <= accWrap[MOD_W-1:0];
    end
  end
endmodule

// File: rtl/fracSdm.sv
module fracSdm
  import sdmPkg::*;
#(
  parameter int INT_W = 12,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updStb,
  input  logic [INT_W-1:0] intIn,
  input  logic [MOD_W-1:0] fracIn,
  input  logic [MOD_W-1:0] modIn,
  input  logic [MOD_W-1:0] phaseIn,
  output logic [INT_W:0]   nOut,
  output logic [MOD_W-1:0] residue
);
  sdmStrobe_t strb;

  sdmCtrl #(.MOD_W(MOD_W)) uCtrl (
    .updStb (updStb),
    .fracIn (fracIn),
    .modIn  (modIn),
    .phaseIn(phaseIn),
    .strb   (strb)
  );

  sdmPath #(.INT_W(INT_W), .MOD_W(MOD_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .intIn  (intIn),
    .fracIn (fracIn),
    .modIn  (modIn),
    .phaseIn(phaseIn),
    .nOut   (nOut),
    .residue(residue)
  );
endmodule

// File: rtl/fracSdmChk.sv
module fracSdmChk #(
  parameter int INT_W = 12,
  parameter int MOD_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             updStb,
  input logic [INT_W-1:0] intIn,
  input logic [MOD_W-1:0] fracIn,
  input logic [MOD_W-1:0] modIn,
  input logic [MOD_W-1:0] phaseIn,
  input logic [INT_W:0]   nOut,
  input logic [MOD_W-1:0] residue
);
  logic [INT_W-1:0] chkInt;
  logic [MOD_W-1:0] chkFrac;
  logic [MOD_W-1:0] chkMod;
  logic             okIn;
  logic [MOD_W:0]   expRes;

  assign okIn   = updStb && (modIn != '0) && (fracIn < modIn) && (phaseIn < modIn);
  assign expRes = ({1'b0, residue} + {1'b0, chkFrac}) % {1'b0, chkMod};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkInt  <= '0;
      chkFrac <= '0;
      chkMod  <= MOD_W'(1);
    end else if (okIn) begin
      chkInt  <= intIn;
      chkFrac <= fracIn;
      chkMod  <= modIn;
    end
  end

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    okIn |=> (residue == $past(phaseIn))); // R2

  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rstN)
    !okIn |=> ({1'b0, residue} == $past(expRes))); // R3

  AST_RES_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    residue < chkMod); // R3

  AST_N_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (nOut == {1'b0, chkInt}) || (nOut == ({1'b0, chkInt} + 1'b1))); // R4

  AST_FLAT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (chkFrac == '0) |-> (nOut == {1'b0, chkInt})); // R9

  AST_HOLD_SEED: assert property (@(posedge clk) disable iff (!rstN)
    (okIn && $past(okIn) && (phaseIn == $past(phaseIn))) |=> $stable(residue)); // R8
endmodule

bind fracSdm fracSdmChk #(.INT_W(INT_W), .MOD_W(MOD_W)) uChk (
  .clk(clk), .rstN(rstN), .updStb(updStb), .intIn(intIn), .fracIn(fracIn),
  .modIn(modIn), .phaseIn(phaseIn), .nOut(nOut), .residue(residue)
);

// File: tb/sim_fracSdm.sv
module sim_fracSdm;
  localparam int INT_W = 12;
  localparam int MOD_W = 12;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             updStb = 1'b0;
  logic [INT_W-1:0] intIn = '0;
  logic [MOD_W-1:0] fracIn = '0;
  logic [MOD_W-1:0] modIn = '0;
  logic [MOD_W-1:0] phaseIn = '0;
  logic [INT_W:0]   nOut;
  logic [MOD_W-1:0] residue;

  int total = 0;
  int bad = 0;
  int mInt = 0, mFrac = 0, mMod = 1, mAcc = 0;
  int lastN = 0, lastRes = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracSdm #(.INT_W(INT_W), .MOD_W(MOD_W)) u0 (
    .clk(clk), .rstN(rstN), .updStb(updStb), .intIn(intIn), .fracIn(fracIn),
    .modIn(modIn), .phaseIn(phaseIn), .nOut(nOut), .residue(residue)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge: compare, drive the next edge, advance the model.
  task automatic tick(bit u, int i, int f, int m, int p, string tag);
    int expN;
    expN = mInt + (((mAcc + mFrac) >= mMod) ? 1 : 0);
    lastN = int'(nOut);
    lastRes = int'(residue);
    check({tag, " nOut"}, lastN, expN);
    check({tag, " residue"}, lastRes, mAcc);
    updStb  = u;
    intIn   = INT_W'(i);
    fracIn  = MOD_W'(f);
    modIn   = MOD_W'(m);
    phaseIn = MOD_W'(p);
    if (u && m != 0 && f < m && p < m) begin
      mInt = i; mFrac = f; mMod = m; mAcc = p;
    end else begin
      mAcc = (mAcc + mFrac) % mMod;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    int carries;
    int seqQ[$];
    repeat (3) @(negedge clk);
    check("R1 reset nOut", int'(nOut), 0);
    check("R1 reset residue", int'(residue), 0);
    rstN = 1'b1;
    idle(3, "R1");

    // Seed and run a full modulus period
    tick(1, 144, 40, 65, 26, "R2");
    carries = 0;
    for (int k = 0; k < 65; k++) begin
      tick(0, 0, 0, 0, 0, "R3 R4");
      if (lastN == 145) carries++;
    end
    check("R5 carry count", carries, 40);

    // Repeatability
    tick(1, 144, 40, 65, 26, "R7 reseed");
    for (int k = 0; k < 20; k++) begin
      tick(0, 0, 0, 0, 0, "R7 first");
      seqQ.push_back(lastN * 4096 + lastRes);
    end
    idle(7, "R3");
    tick(1, 144, 40, 65, 26, "R7 reseed");
    for (int k = 0; k < 20; k++) begin
      tick(0, 0, 0, 0, 0, "R7 second");
      check("R7 replay", lastN * 4096 + lastRes, seqQ[k]);
    end

    // Invalid updates are dropped mid-run
    tick(1, 300, 70, 65, 3, "R6 frac");
    tick(1, 300, 10, 65, 65, "R6 phase");
    tick(1, 300, 0, 0, 0, "R6 mod");
    idle(5, "R6");

    // Back-to-back reseeds, some on carry cycles
    for (int k = 0; k < 4; k++) tick(1, 500, 60, 65, 10, "R8");
    idle(4, "R8");
    for (int k = 0; k < 3; k++) tick(1, 500, 60, 65, 63, "R8 carry");
    idle(3, "R8");

    // Zero fraction
    tick(1, 100, 0, 65, 7, "R9");
    idle(10, "R9");

    // Extremes
    tick(1, 4095, 64, 65, 64, "R4 max");
    carries = 0;
    for (int k = 0; k < 65; k++) begin
      tick(0, 0, 0, 0, 0, "R4 max");
      if (lastN == 4096) carries++;
    end
    check("R5 max carry count", carries, 64);
    tick(1, 20, 0, 1, 0, "R2 mod1");
    idle(5, "R9 mod1");
    tick(1, 20, 1, 2, 1, "R2 half");
    idle(6, "R4 half");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule